// File: doc/BRIEF.md
# Prescaled Interrupt Pin Glitch Filter

This block cleans up a group of external interrupt pins before they reach the interrupt controller. Every pin is first brought into the system clock domain through a two-stage synchronizer. A shared prescaler derives a sampling strobe from the system clock, and the period of that strobe is a power of two picked by a 3-bit select code. Each channel holds a small agreement counter. A new level reaches the filtered output only after eight strobe samples in a row have disagreed with the level currently held. Shorter disturbances are absorbed without leaving any trace.

Behind each filter sits a detector. Its 2-bit mode selects rising-edge, falling-edge, high-level or low-level matching, and it registers an interrupt request whenever the filtered level matches that mode. A channel with its filter disabled passes the synchronized pin straight through, so it still works when the select code stops the sampling strobe. All configuration arrives as plain input vectors.

Top module: `igf_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every filtered level and every interrupt request is 0.
- R2: For select code c from 1 to 7 the sampling strobe has a period of 2^c system clocks. A steady change on an enabled channel appears on its filtered level no earlier than 7*2^c+3 and no later than 8*2^c+2 clock edges after the pin changes.
- R3: On an enabled channel, a pulse shorter than 7 strobe periods never changes the filtered level.
- R4: On an enabled channel, a pulse of 8 or more strobe periods is always passed to the filtered level. For a pulse between 7 and 8 periods, either outcome is acceptable.
- R5: Any strobe sample that matches the held level clears the channel's agreement count. Two 5-period pulses separated by a 2-period gap are therefore rejected.
- R6: Select code 0 stops the strobe. Enabled channels then hold their filtered level and count for as long as the code stays 0, whatever the pin does.
- R7: A channel whose filter enable is 0 drives its filtered level from the synchronized pin, two clock edges after the pin changes.
- R8: Mode 3 (rising) raises the request for exactly one cycle, on the clock edge after the filtered level goes from 0 to 1. A falling transition raises nothing in this mode.
- R9: Mode 2 (falling) raises the request for exactly one cycle, on the clock edge after the filtered level goes from 1 to 0.
- R10: Mode 1 (high level) drives the request, one edge later, to the filtered level for as long as the level stays 1.
- R11: Mode 0 (low level) drives the request, one edge later, to the inverted filtered level for as long as the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Strobe select code; 0 stops the strobe, c gives a period of 2^c clocks |
| filt_en | input | NCH | Per-channel filter enable; 0 selects bypass |
| det_mode | input | 2*NCH | Per-channel detect mode, 2 bits each: 0 low, 1 high, 2 falling, 3 rising |
| pin_in | input | NCH | Raw external interrupt pins |
| lvl_out | output | NCH | Filtered (or bypassed) pin levels |
| irq_out | output | NCH | Interrupt requests |

## Verification
The hardest case to reach from the ports is a disturbance that almost passes: a pulse close to the acceptance length, or two sub-threshold pulses joined by a gap just long enough to be sampled. Whether such a case is accepted depends on the prescaler phase, and that phase is invisible. The stimulus avoids the ambiguity by driving pulse widths in whole multiples of the strobe period. It asserts rejection only below 7 periods and acceptance only at 8 or more. Every latency is checked against a window derived from the unknown phase, never against a single cycle.

// File: rtl/igf_pkg.sv
package igf_pkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'd0,
    DET_HIGH = 2'd1,
    DET_FALL = 2'd2,
    DET_RISE = 2'd3
  } det_mode_e;

  // Request condition for a given mode, current level and level one edge ago.
  function automatic logic det_fire(input det_mode_e mode, input logic lvl,
                                    input logic prev);
    logic hit;
    case (mode)
      DET_LOW:  hit = !lvl;
      DET_HIGH: hit = lvl;
      DET_FALL: hit = prev && !lvl;
      default:  hit = lvl && !prev;
    endcase
    return hit;
  endfunction

  // Low-order ones mask of width w with the c lowest bits set.
  function automatic logic [15:0] low_ones(input int unsigned c);
    logic [15:0] m;
    m = '0;
    for (int unsigned k = 0; k < 16; k++) begin
      if (k < c) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/igf_prescaler.sv
module igf_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import igf_pkg::*;

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             run;

  assign run  = (sel != '0);
  assign mask = DIV_W'(low_ones(int'(sel)));
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/igf_chan_filter.sv
module igf_chan_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  localparam int CNT_W      = $clog2(FILT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             pin,
  output logic             sync_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             filt_o,
  output logic             lvl_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;
  logic                   differ;
  logic                   accept;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = sync_q[SYNC_STAGES-1];
  assign differ = (sync_o != filt_q);
  assign accept = tick && differ && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= '0;
      filt_q <= sync_o;
    end else if (tick) begin
      if (!differ) begin
        cnt_q <= '0;
      end else if (accept) begin
        cnt_q  <= '0;
        filt_q <= sync_o;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign filt_o = filt_q;
  assign lvl_o  = en ? filt_q : sync_o;

endmodule

// File: rtl/igf_detect.sv
module igf_detect (
  input  logic                clk,
  input  logic                rst_n,
  input  igf_pkg::det_mode_e  mode,
  input  logic                lvl,
  output logic                prev_o,
  output logic                irq_o
);
  import igf_pkg::*;

  logic prev_q;
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      irq_q  <= det_fire(mode, lvl, prev_q);
    end
  end

  assign prev_o = prev_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/igf_top.sv
module igf_top #(
  parameter int NCH         = 4,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [NCH-1:0]   filt_en,
  input  logic [2*NCH-1:0] det_mode,
  input  logic [NCH-1:0]   pin_in,
  output logic [NCH-1:0]   lvl_out,
  output logic [NCH-1:0]   irq_out
);
  import igf_pkg::*;

  localparam int CNT_W = $clog2(FILT_LEN);

  // Internal events brought out by name for the checker.
  logic                 samp_tick;
  logic [NCH-1:0]       chan_sync;
  logic [NCH-1:0]       chan_filt;
  logic [NCH-1:0]       chan_prev;
  logic [NCH*CNT_W-1:0] chan_cnt;

  igf_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel),
    .tick  (samp_tick)
  );

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      det_mode_e mode_i;
      assign mode_i = det_mode_e'(det_mode[2*i +: 2]);

      igf_chan_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
      ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (samp_tick),
        .en     (filt_en[i]),
        .pin    (pin_in[i]),
        .sync_o (chan_sync[i]),
        .cnt_o  (chan_cnt[i*CNT_W +: CNT_W]),
        .filt_o (chan_filt[i]),
        .lvl_o  (lvl_out[i])
      );

      igf_detect u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_i),
        .lvl    (lvl_out[i]),
        .prev_o (chan_prev[i]),
        .irq_o  (irq_out[i])
      );
    end
  endgenerate

endmodule

// File: rtl/igf_checker.sv
module igf_checker #(
  parameter int NCH      = 4,
  parameter int SEL_W    = 3,
  parameter int FILT_LEN = 8,
  localparam int CNT_W   = $clog2(FILT_LEN)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SEL_W-1:0]     clk_sel,
  input logic [NCH-1:0]       filt_en,
  input logic [2*NCH-1:0]     det_mode,
  input logic [NCH-1:0]       pin_in,
  input logic [NCH-1:0]       lvl_out,
  input logic [NCH-1:0]       irq_out,
  input logic                 samp_tick,
  input logic [NCH-1:0]       chan_filt,
  input logic [NCH*CNT_W-1:0] chan_cnt
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lvl_out == '0 && irq_out == '0));

  a_r6_no_strobe_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == '0) |-> !samp_tick);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en[i] && !samp_tick) |=> $stable(chan_filt[i]));

      a_r3_needs_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en[i] && samp_tick && chan_cnt[i*CNT_W +: CNT_W] != CNT_LAST)
        |=> $stable(chan_filt[i]));

      a_r7_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3 && !filt_en[i]) |-> (lvl_out[i] == $past(pin_in[i], 2)));

      a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out[i] && det_mode[2*i +: 2] == 2'd3)
        |=> (!irq_out[i] || !$stable(det_mode[2*i +: 2])));

      a_r10_high_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (det_mode[2*i +: 2] == 2'd1) |=> (irq_out[i] == $past(lvl_out[i])));

      a_r11_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (det_mode[2*i +: 2] == 2'd0) |=> (irq_out[i] == !$past(lvl_out[i])));
    end
  endgenerate

endmodule

bind igf_top igf_checker #(
  .NCH      (NCH),
  .SEL_W    (SEL_W),
  .FILT_LEN (FILT_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_sel   (clk_sel),
  .filt_en   (filt_en),
  .det_mode  (det_mode),
  .pin_in    (pin_in),
  .lvl_out   (lvl_out),
  .irq_out   (irq_out),
  .samp_tick (samp_tick),
  .chan_filt (chan_filt),
  .chan_cnt  (chan_cnt)
);

// File: tb/igf_top_bench.sv
module igf_top_bench;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     clk_sel = 3'd1;
  logic [NCH-1:0] filt_en = '1;
  logic [2*NCH-1:0] det_mode = {4{2'd3}};
  logic [NCH-1:0] pin_in = '0;
  logic [NCH-1:0] lvl_out;
  logic [NCH-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  igf_top u_igf_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .filt_en  (filt_en),
    .det_mode (det_mode),
    .pin_in   (pin_in),
    .lvl_out  (lvl_out),
    .irq_out  (irq_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int per(input int c);
    return 1 << c;
  endfunction

  // Count cycles with irq on channel ch high over n cycles.
  task automatic count_irq(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (irq_out[ch]) cnt++;
    end
  endtask

  task automatic t_reset();
    step(1);
    chk(lvl_out == '0, "R1 lvl during reset", lvl_out, 0);
    chk(irq_out == '0, "R1 irq during reset", irq_out, 0);
    rst_n = 1'b1;
    step(1);
    chk(lvl_out == '0 && irq_out == '0, "R1 after reset", {lvl_out, irq_out}, 0);
  endtask

  // R2: latency window on channel 0 for code c, both directions.
  task automatic t_latency(input int c);
    int p = per(c);
    int pulses;
    clk_sel = 3'(c);
    step(2 * p);
    pin_in[0] = 1'b1;
    step(7 * p + 2);
    chk(lvl_out[0] == 1'b0, $sformatf("R2 code %0d not early rise", c), lvl_out[0], 0);
    step(p);
    chk(lvl_out[0] == 1'b1, $sformatf("R2 code %0d rise by limit", c), lvl_out[0], 1);
    pin_in[0] = 1'b0;
    step(7 * p + 2);
    chk(lvl_out[0] == 1'b1, $sformatf("R2 code %0d not early fall", c), lvl_out[0], 1);
    count_irq(0, p, pulses);
    chk(lvl_out[0] == 1'b0, $sformatf("R2 code %0d fall by limit", c), lvl_out[0], 0);
    chk(pulses == 0, "R8 no request on falling in rise mode", pulses, 0);
  endtask

  // Pulse of w cycles on channel 0, then watch for the max level seen.
  task automatic pulse_watch(input int w, input int watch, output int seen);
    seen = 0;
    pin_in[0] = 1'b1;
    for (int k = 0; k < w; k++) begin
      step(1);
      if (lvl_out[0]) seen = 1;
    end
    pin_in[0] = 1'b0;
    for (int k = 0; k < watch; k++) begin
      step(1);
      if (lvl_out[0]) seen = 1;
    end
  endtask

  task automatic t_noise();
    int p = per(2);
    int seen;
    clk_sel = 3'd2;
    step(2 * p);
    pulse_watch(6 * p, 12 * p, seen);
    chk(seen == 0, "R3 short pulse rejected", seen, 0);
    pulse_watch(10 * p, 12 * p, seen);
    chk(seen == 1, "R4 long pulse accepted", seen, 1);
    chk(lvl_out[0] == 1'b0, "R4 level returns low", lvl_out[0], 0);
    pulse_watch(7 * p + p / 2, 12 * p, seen);
    chk(lvl_out[0] == 1'b0, "R4 band pulse settles low", lvl_out[0], 0);
  endtask

  task automatic t_restart();
    int p = per(2);
    int seen = 0;
    pin_in[0] = 1'b1;
    for (int k = 0; k < 5 * p; k++) begin step(1); if (lvl_out[0]) seen = 1; end
    pin_in[0] = 1'b0;
    for (int k = 0; k < 2 * p; k++) begin step(1); if (lvl_out[0]) seen = 1; end
    pin_in[0] = 1'b1;
    for (int k = 0; k < 5 * p; k++) begin step(1); if (lvl_out[0]) seen = 1; end
    pin_in[0] = 1'b0;
    for (int k = 0; k < 12 * p; k++) begin step(1); if (lvl_out[0]) seen = 1; end
    chk(seen == 0, "R5 gap clears count", seen, 0);
  endtask

  task automatic t_freeze();
    int pulses;
    clk_sel = 3'd0;
    step(2);
    pin_in[0] = 1'b1;
    step(300);
    chk(lvl_out[0] == 1'b0, "R6 frozen level holds", lvl_out[0], 0);
    clk_sel = 3'd1;
    count_irq(0, 8 * 2 + 4, pulses);
    chk(lvl_out[0] == 1'b1, "R6 resumes after restart", lvl_out[0], 1);
    chk(pulses == 1, "R8 one rising pulse", pulses, 1);
    pin_in[0] = 1'b0;
    step(8 * 2 + 4);
  endtask

  task automatic t_bypass();
    filt_en[1] = 1'b0;
    det_mode[3:2] = 2'd1;
    clk_sel = 3'd0;
    step(3);
    pin_in[1] = 1'b1;
    step(1);
    chk(lvl_out[1] == 1'b0, "R7 bypass not before two edges", lvl_out[1], 0);
    step(1);
    chk(lvl_out[1] == 1'b1, "R7 bypass after two edges", lvl_out[1], 1);
    chk(irq_out[1] == 1'b0, "R10 request one edge later", irq_out[1], 0);
    step(1);
    chk(irq_out[1] == 1'b1, "R10 high level request", irq_out[1], 1);
    step(5);
    chk(irq_out[1] == 1'b1, "R10 request held", irq_out[1], 1);
    pin_in[1] = 1'b0;
    step(3);
    chk(irq_out[1] == 1'b0, "R10 request drops", irq_out[1], 0);
  endtask

  task automatic t_low();
    filt_en[2] = 1'b0;
    det_mode[5:4] = 2'd0;
    step(2);
    chk(irq_out[2] == 1'b1, "R11 low level request", irq_out[2], 1);
    pin_in[2] = 1'b1;
    step(3);
    chk(irq_out[2] == 1'b0, "R11 request drops when high", irq_out[2], 0);
    pin_in[2] = 1'b0;
    step(3);
    chk(irq_out[2] == 1'b1, "R11 request returns", irq_out[2], 1);
  endtask

  task automatic t_edges();
    int pulses;
    filt_en[3] = 1'b0;
    det_mode[7:6] = 2'd2;
    step(2);
    pin_in[3] = 1'b1;
    count_irq(3, 8, pulses);
    chk(pulses == 0, "R9 no request on rise in fall mode", pulses, 0);
    pin_in[3] = 1'b0;
    count_irq(3, 8, pulses);
    chk(pulses == 1, "R9 one falling pulse", pulses, 1);
    det_mode[7:6] = 2'd3;
    step(2);
    pin_in[3] = 1'b1;
    count_irq(3, 8, pulses);
    chk(pulses == 1, "R8 one rising pulse bypassed", pulses, 1);
  endtask

  initial begin
    t_reset();
    t_latency(1);
    t_latency(3);
    t_noise();
    t_restart();
    t_freeze();
    t_bypass();
    t_low();
    t_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule